// File: doc/BRIEF.md
# Nibble-Serial Clock-Chip Register Access Master

This block transfers one 4-bit register to or from a real-time-clock device over a three-wire serial link made of a chip-enable line, a serial clock and a single bidirectional data line. A host raises `start` for one cycle together with a read/write select, a 4-bit register address and, for writes, a 4-bit value. The block raises chip enable, lets it settle and clocks out a 16-bit frame. It then drops chip enable, lets it settle again and pulses `done`. After a read, the captured nibble is on `rdata`.

Every frame opens with a control nibble that tells the device the transfer direction and whether an address or data phase follows. The address nibble comes next.
- On a read, the master turns the data line around. It clocks four filler bits, which it discards, and then four data bits.
- On a write, the master sends a second control nibble that marks the data phase, and then the data nibble.

The data line is split into separate out, in and output-enable signals so that a pad cell can be placed outside the block.

Top module: `nrtc_master`

## Requirements
- R1: While `rst` is high and after it ends: `scl`=1, `ce`=0, `sd_oe`=0, `busy`=0, `done`=0 and `rdata`=0. Whenever `ce` is low, `scl` is high and `sd_oe` is low.
- R2: A read frame drives eight bits, MSB first on each falling `scl` edge: 1,1,1,0 and then the address bits A3..A0. `sd_oe` is high for all eight.
- R3: A read frame has eight more clock periods with `sd_oe` low. The first four sampled `sd_in` bits are discarded. The last four are D3..D0, MSB first, and appear on `rdata` with `done`.
- R4: A write frame drives all sixteen bits with `sd_oe` high, in this order: 1,0,1,0, then A3..A0, then 1,0,0,1, then D3..D0.
- R5: `scl` idles high. Each bit holds `scl` high for HALF_CYC cycles with its data set, then low for HALF_CYC cycles. Consecutive falling edges are therefore 2*HALF_CYC cycles apart.
- R6: `sd_in` is sampled at the end of the high half of a bit, on the same edge that drives `scl` low.
- R7: The first `scl` fall comes SETTLE_CYC+HALF_CYC cycles after `ce` rises. `ce` falls HALF_CYC cycles after the last `scl` fall. `done` pulses SETTLE_CYC cycles after `ce` falls.
- R8: `busy` rises in the cycle after `start` is accepted and stays high until `done`. `done` is a one-cycle pulse, and `busy` is low in that cycle.
- R9: A `start` while `busy` is high is ignored. The frame in progress is unchanged and only one `done` occurs.
- R10: `rdata` changes only when `done` ends a read. A write leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 4 | Write value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Last value read |
| ce | output | 1 | Device chip enable |
| scl | output | 1 | Serial clock, idles high |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_in | input | 1 | Data line input value |

## Verification
The hardest case to reach is the read turnaround, where the master must discard the four filler bits and keep exactly the next four. The responder drives an alternating pattern on the filler bits and a different value on the data bits, so a shifted capture window gives a wrong nibble.

The sample point is probed by changing `sd_in` only right after each falling edge. The bench sweeps every address:
- a read of a preloaded value;
- a write of a computed value, with a second `start` injected mid-frame;
- a read-back of the written value.

// File: rtl/nrtc_pkg.sv
package nrtc_pkg;

    localparam int NIB_W   = 4;
    localparam int FRAME_W = 4 * NIB_W;

    // control nibbles: {spare, read flag, address phase, data phase}
    localparam logic [NIB_W-1:0] CTL_RD_ADDR = 4'b1110;
    localparam logic [NIB_W-1:0] CTL_WR_ADDR = 4'b1010;
    localparam logic [NIB_W-1:0] CTL_WR_DATA = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CE_ON,
        ST_HI,
        ST_LO,
        ST_CE_OFF
    } nrtc_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // MSB goes out first
        logic [FRAME_W-1:0] drive;  // 1 = master drives that bit
    } nrtc_frame_t;

    function automatic nrtc_frame_t build_frame(
        input logic             rd,
        input logic [NIB_W-1:0] a,
        input logic [NIB_W-1:0] d
    );
        nrtc_frame_t f;
        if (rd) begin
            f.bits  = {CTL_RD_ADDR, a, {(2*NIB_W){1'b0}}};
            f.drive = {{(2*NIB_W){1'b1}}, {(2*NIB_W){1'b0}}};
        end else begin
            f.bits  = {CTL_WR_ADDR, a, CTL_WR_DATA, d};
            f.drive = {FRAME_W{1'b1}};
        end
        return f;
    endfunction

endpackage

// File: rtl/nrtc_timer.sv
module nrtc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/nrtc_shifter.sv
module nrtc_shifter
    import nrtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  nrtc_frame_t      frame,
    input  logic             advance,
    input  logic             capture,
    input  logic             sdi,
    output logic             head_bit,
    output logic             head_drive,
    output logic [NIB_W-1:0] rx_nib
);
    nrtc_frame_t sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            rx_nib <= '0;
        end else begin
            if (load)
                sh <= frame;
            else if (advance) begin
                sh.bits  <= {sh.bits[FRAME_W-2:0], 1'b0};
                sh.drive <= {sh.drive[FRAME_W-2:0], 1'b0};
            end
            if (capture)
                rx_nib <= {rx_nib[NIB_W-2:0], sdi};
        end
    end

    assign head_bit   = sh.bits[FRAME_W-1];
    assign head_drive = sh.drive[FRAME_W-1];
endmodule

// File: rtl/nrtc_master.sv
module nrtc_master
    import nrtc_pkg::*;
#(
    parameter int HALF_CYC   = 60000,
    parameter int SETTLE_CYC = 120000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_nwr,
    input  logic [NIB_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    output logic             busy,
    output logic             done,
    output logic [NIB_W-1:0] rdata,
    output logic             ce,
    output logic             scl,
    output logic             sd_out,
    output logic             sd_oe,
    input  logic             sd_in
);
    localparam int CNT_MAX   = (HALF_CYC > SETTLE_CYC) ? HALF_CYC : SETTLE_CYC;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int IDX_W     = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] HALF_LD   = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] IDX_RX    = IDX_W'(2 * NIB_W);
    localparam logic [IDX_W-1:0] IDX_CAP   = IDX_W'(FRAME_W - NIB_W);

    nrtc_state_e      st, st_nxt;
    logic [IDX_W-1:0] bit_idx;
    logic             is_rd;
    logic             tz, tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_adv, cap;
    logic             head_bit, head_drive;
    logic [NIB_W-1:0] rx_nib;
    logic             in_bits;

    nrtc_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tz)
    );

    nrtc_shifter i_shifter (
        .clk        (clk),
        .rst        (rst),
        .load       (sh_load),
        .frame      (build_frame(rd_nwr, addr, wdata)),
        .advance    (sh_adv),
        .capture    (cap),
        .sdi        (sd_in),
        .head_bit   (head_bit),
        .head_drive (head_drive),
        .rx_nib     (rx_nib)
    );

    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        cap      = 1'b0;
        case (st)
            ST_IDLE: if (start) begin
                st_nxt   = ST_CE_ON;
                tmr_load = 1'b1;
                tmr_val  = SETTLE_LD;
                sh_load  = 1'b1;
            end
            ST_CE_ON: if (tz) begin
                st_nxt   = ST_HI;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
            end
            ST_HI: if (tz) begin
                st_nxt   = ST_LO;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
                cap      = is_rd && (bit_idx >= IDX_CAP);
            end
            ST_LO: if (tz) begin
                tmr_load = 1'b1;
                if (bit_idx == IDX_LAST) begin
                    st_nxt  = ST_CE_OFF;
                    tmr_val = SETTLE_LD;
                end else begin
                    st_nxt  = ST_HI;
                    tmr_val = HALF_LD;
                    sh_adv  = 1'b1;
                end
            end
            ST_CE_OFF: if (tz) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_idx <= '0;
            is_rd   <= 1'b0;
            ce      <= 1'b0;
            scl     <= 1'b1;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            st   <= st_nxt;
            done <= 1'b0;
            if (st == ST_IDLE && start) begin
                ce      <= 1'b1;
                is_rd   <= rd_nwr;
                bit_idx <= '0;
            end
            if (st == ST_HI && tz)
                scl <= 1'b0;
            if (st == ST_LO && tz) begin
                scl <= 1'b1;
                if (bit_idx == IDX_LAST) ce <= 1'b0;
            end
            if (sh_adv)
                bit_idx <= bit_idx + 1'b1;
            if (st == ST_CE_OFF && tz) begin
                done <= 1'b1;
                if (is_rd) rdata <= rx_nib;
            end
        end
    end

    assign in_bits = (st == ST_HI) || (st == ST_LO);
    assign busy    = (st != ST_IDLE);
    assign sd_oe   = in_bits && head_drive;
    assign sd_out  = sd_oe && head_bit;

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !ce |-> (scl && !sd_oe));                                   // R1
    AST_RX_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (in_bits && is_rd && bit_idx >= IDX_RX) |-> !sd_oe);        // R3
    AST_FALL_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        $fell(scl) |-> ce);                                         // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                            // R8
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                                      // R8
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);                                  // R10
endmodule

// File: tb/test_nrtc_master.sv
`timescale 1ns/1ps
module test_nrtc_master;
    localparam int H = 3;
    localparam int S = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wdata = '0;
    logic       busy, done, ce, scl, sd_out, sd_oe;
    logic [3:0] rdata;
    logic       sd_in = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nrtc_master #(.HALF_CYC(H), .SETTLE_CYC(S)) i_nrtc_master (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .addr(addr), .wdata(wdata), .busy(busy), .done(done),
        .rdata(rdata), .ce(ce), .scl(scl), .sd_out(sd_out),
        .sd_oe(sd_oe), .sd_in(sd_in)
    );

    // responder and monitor, sampled away from the active edge
    logic [3:0]  mem [16];
    logic [15:0] got_bits, got_oe;
    int          nb, cyc, ndone;
    int          t_ce_on, t_ce_off, t_done;
    int          fall_t [16];
    logic        ce_q = 1'b0, scl_q = 1'b1;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 4'((i * 7 + 3) & 15);
    end

    always @(negedge clk) begin
        cyc++;
        if (ce && !ce_q) begin t_ce_on = cyc; nb = 0; end
        if (!ce && ce_q) t_ce_off = cyc;
        if (done) begin t_done = cyc; ndone++; end
        if (!scl && scl_q && nb < 16) begin
            got_bits[15-nb] = sd_out;
            got_oe[15-nb]   = sd_oe;
            fall_t[nb]      = cyc;
            nb++;
            if (got_bits[14] && nb >= 8 && nb < 16) begin
                if (nb >= 12) sd_in = mem[got_bits[11:8]][15-nb];
                else          sd_in = nb[0];
            end else
                sd_in = 1'b0;
            if (nb == 16 && !got_bits[14] && got_bits[7:4] == 4'b1001)
                mem[got_bits[11:8]] = got_bits[3:0];
        end
        ce_q  = ce;
        scl_q = scl;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic txn(input bit rd, input logic [3:0] a, input logic [3:0] d,
                       input bit inject);
        logic [3:0] exp_rd, prev_rd;
        int         d0;
        int         wd;
        exp_rd  = mem[a];
        prev_rd = rdata;
        d0      = ndone;
        @(negedge clk);
        rd_nwr = rd; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R8 busy after start", busy, 1);
        if (inject) begin
            repeat (40) @(negedge clk);
            rd_nwr = ~rd; addr = ~a; wdata = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wd = 0;
        while (!done && wd < 2000) begin @(negedge clk); wd++; end
        check(wd < 2000, "R8 done reached", wd, 0);
        check(busy === 1'b0, "R8 busy low with done", busy, 0);
        @(negedge clk);
        check(done === 1'b0, "R8 done one cycle", done, 0);
        check(ndone - d0 == 1, "R9 single done", ndone - d0, 1);
        if (rd) begin
            check(got_bits[15:8] == {4'b1110, a}, "R2 read header", got_bits[15:8], {4'b1110, a});
            check(got_oe == 16'hFF00, "R2 R3 oe mask", got_oe, 16'hFF00);
            check(rdata == exp_rd, "R3 R6 read data", rdata, exp_rd);
        end else begin
            check(got_bits == {4'b1010, a, 4'b1001, d}, "R4 write frame",
                  got_bits, {4'b1010, a, 4'b1001, d});
            check(got_oe == 16'hFFFF, "R4 oe mask", got_oe, 16'hFFFF);
            check(rdata == prev_rd, "R10 rdata kept on write", rdata, prev_rd);
        end
        check(fall_t[0] - t_ce_on == S + H, "R7 ce to first fall", fall_t[0] - t_ce_on, S + H);
        for (int i = 0; i < 15; i++)
            check(fall_t[i+1] - fall_t[i] == 2 * H, "R5 bit period",
                  fall_t[i+1] - fall_t[i], 2 * H);
        check(t_ce_off - fall_t[15] == H, "R7 last fall to ce off", t_ce_off - fall_t[15], H);
        check(t_done - t_ce_off == S, "R7 ce off to done", t_done - t_ce_off, S);
        check(ce === 1'b0 && scl === 1'b1 && sd_oe === 1'b0, "R1 lines idle", {ce, scl, sd_oe}, 3'b010);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(scl === 1'b1 && ce === 1'b0 && sd_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
              "R1 in reset", {scl, ce, sd_oe, busy, done}, 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        check(rdata === 4'h0 && busy === 1'b0 && scl === 1'b1, "R1 after reset", rdata, 0);
        for (int a = 0; a < 16; a++) txn(1'b1, 4'(a), 4'h0, 1'b0);
        for (int a = 0; a < 16; a++) txn(1'b0, 4'(a), 4'((a * 5 + 9) & 15), a[0]);
        for (int a = 0; a < 16; a++) begin
            check(mem[a] == 4'((a * 5 + 9) & 15), "R4 R9 device holds write",
                  mem[a], (a * 5 + 9) & 15);
            txn(1'b1, 4'(a), 4'h0, a[1]);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule